// File: doc/BRIEF.md
# Asynchronous Static RAM Byte-Lane Controller

This block lets a clocked request/response interface inside a chip drive an external asynchronous static RAM of 256K words by 16 bits. The RAM has active-low select, output enable, write enable, and separate enables for its low byte (data bits 7:0) and high byte (data bits 15:8). The controller accepts one request at a time through a ready/valid handshake. A request carries an 18-bit word address, 16 bits of write data and a 2-bit byte mask. The controller then drives the memory pins through a fixed sequence of phases and, for a read, returns the word with a one-cycle valid strobe.

Each phase length is worked out when the block is elaborated. A nanosecond minimum is divided by the clock period parameter and rounded up, with a floor of one cycle. The write pulse covers both the write-enable width and the data setup time. The read sample point waits out the longest of address access, output-enable access and read cycle time. The data-bus driver is split into value, enable and input ports. The pad tristate sits outside the block.

The state machine has five states. IDLE leaves every pin in standby. When a request is accepted in IDLE, the machine takes one of three transitions. A read goes to RD_ACCESS. A write with a nonzero mask goes to WR_SETUP. A write with mask 2'b00 stays in IDLE and is acknowledged as a no-op. WR_SETUP always moves to WR_PULSE. WR_PULSE moves to WR_HOLD when its phase timer expires. WR_HOLD always returns to IDLE. RD_ACCESS returns to IDLE when its phase timer expires, capturing the data bus on that edge. A separate cycle-time timer keeps `req_ready` low in IDLE until the previous access's cycle-time minimum has run out.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset the block drives standby pins: mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n and mem_ub_n all 1, mem_dq_oe 0, rsp_valid 0, and req_ready 1.
- R2: A write holds mem_we_n low for exactly NW = max(ceil(40/P), ceil(25/P)) consecutive cycles, where P is CLK_PERIOD_NS. During that pulse mem_cs_n is low, mem_oe_n is high, and mem_addr and mem_dq_out are stable. One setup cycle with data driven comes before the pulse, and one hold cycle with data driven comes after it.
- R3: During a write, mask bit 0 set drives mem_lb_n low, which writes data bits 7:0. Mask bit 1 set drives mem_ub_n low, which writes bits 15:8. A clear mask bit leaves that lane's byte in memory unchanged.
- R4: A write with mask 2'b00 is accepted but never drives mem_we_n low, and it leaves the addressed word unchanged.
- R5: A read drives mem_cs_n, mem_oe_n, mem_lb_n and mem_ub_n low with mem_we_n high for NR = max(ceil(55/P), ceil(25/P)) cycles. It samples mem_dq_in at the edge that ends this window. rsp_valid is high for exactly one cycle, starting NR cycles after the accepting edge, and rsp_rdata carries the sampled word.
- R6: mem_dq_oe is never 1 while mem_oe_n is 0.
- R7: The starts of two accepted accesses (falling edges of mem_cs_n) are at least NC = ceil(55/P) cycles apart.
- R8: Whenever no access is in progress, mem_cs_n is high.
- R9: Reading an address returns the merge of all earlier writes to it, byte lane by byte lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte lanes to write (bit0 low byte, bit1 high byte) |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 18 | Memory address pins |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_lb_n | output | 1 | Low byte enable, active low |
| mem_ub_n | output | 1 | High byte enable, active low |
| mem_dq_out | output | 16 | Value the controller drives onto the data bus |
| mem_dq_oe | output | 1 | Controller data driver enable |
| mem_dq_in | input | 16 | Value seen on the data bus |

## Verification
The bench builds the block with CLK_PERIOD_NS = 15. None of the nanosecond minimums is then a whole number of cycles, so every phase length depends on rounding up: the pulse is 3 cycles, the read window 4 and the cycle time 4. With these values a write, which takes 5 cycles, outlasts the cycle time, while a read ends exactly on it. Back-to-back reads therefore test the R7 spacing bound at its tightest point.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_ACCESS
    } ctrl_state_e;

    // Whole cycles covering a nanosecond minimum, never fewer than one.
    function automatic int cycles_for(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else if (load)
            count_q <= load_val;
        else if (count_q != '0)
            count_q <= count_q - 1'b1;
    end

    assign expired = (count_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int N_PWE = 4,
    parameter int N_ACC = 6,
    parameter int N_WC  = 6,
    parameter int N_RC  = 6,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    req_bmask,
    input  logic [1:0]    lat_mask,
    input  logic          phase_done,
    input  logic          cycle_done,
    output logic          req_ready,
    output logic          accept,
    output logic          phase_load,
    output logic [CW-1:0] phase_val,
    output logic          cycle_load,
    output logic [CW-1:0] cycle_val,
    output logic          capture,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_lb_n,
    output logic          mem_ub_n,
    output logic          mem_dq_oe
);
    localparam logic [CW-1:0] PWE_LD = CW'(N_PWE - 1);
    localparam logic [CW-1:0] ACC_LD = CW'(N_ACC - 1);
    localparam logic [CW-1:0] WC_LD  = CW'(N_WC - 1);
    localparam logic [CW-1:0] RC_LD  = CW'(N_RC - 1);

    ctrl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state and timer control
    always_comb begin
        state_d    = state_q;
        accept     = 1'b0;
        phase_load = 1'b0;
        phase_val  = '0;
        cycle_load = 1'b0;
        cycle_val  = '0;
        capture    = 1'b0;
        req_ready  = (state_q == ST_IDLE) && cycle_done;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && cycle_done) begin
                    accept = 1'b1;
                    if (!req_write) begin
                        state_d    = ST_RD_ACCESS;
                        phase_load = 1'b1;
                        phase_val  = ACC_LD;
                        cycle_load = 1'b1;
                        cycle_val  = RC_LD;
                    end else if (req_bmask != 2'b00) begin
                        state_d    = ST_WR_SETUP;
                        cycle_load = 1'b1;
                        cycle_val  = WC_LD;
                    end
                end
            end
            ST_WR_SETUP: begin
                state_d    = ST_WR_PULSE;
                phase_load = 1'b1;
                phase_val  = PWE_LD;
            end
            ST_WR_PULSE: begin
                if (phase_done)
                    state_d = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                state_d = ST_IDLE;
            end
            ST_RD_ACCESS: begin
                if (phase_done) begin
                    capture = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Pin outputs per state
    always_comb begin
        mem_cs_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_lb_n  = 1'b1;
        mem_ub_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WR_SETUP, ST_WR_HOLD: begin
                mem_cs_n  = 1'b0;
                mem_lb_n  = ~lat_mask[0];
                mem_ub_n  = ~lat_mask[1];
                mem_dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                mem_cs_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_lb_n  = ~lat_mask[0];
                mem_ub_n  = ~lat_mask[1];
                mem_dq_oe = 1'b1;
            end
            ST_RD_ACCESS: begin
                mem_cs_n = 1'b0;
                mem_oe_n = 1'b0;
                mem_lb_n = 1'b0;
                mem_ub_n = 1'b0;
            end
            default: ;
        endcase
    end

    // Checker state: length of the current write-enable low run
    logic [CW:0] we_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            we_run_q <= '0;
        else if (!mem_we_n)
            we_run_q <= we_run_q + 1'b1;
        else
            we_run_q <= '0;
    end

    a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run_q == (CW+1)'(N_PWE)));

    a_r2_pulse_framing: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));

    a_r4_lane_needed: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !(mem_lb_n && mem_ub_n));

    a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    a_r7_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_cs_n);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_WC_NS       = 55,
    parameter int T_PWE_NS      = 40,
    parameter int T_SD_NS       = 25,
    parameter int T_RC_NS       = 55,
    parameter int T_AA_NS       = 55,
    parameter int T_DOE_NS      = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_bmask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int N_PWE = max2(cycles_for(T_PWE_NS, CLK_PERIOD_NS),
                                cycles_for(T_SD_NS, CLK_PERIOD_NS));
    localparam int N_RC  = cycles_for(T_RC_NS, CLK_PERIOD_NS);
    localparam int N_ACC = max2(max2(cycles_for(T_AA_NS, CLK_PERIOD_NS),
                                     cycles_for(T_DOE_NS, CLK_PERIOD_NS)), N_RC);
    localparam int N_WC  = cycles_for(T_WC_NS, CLK_PERIOD_NS);
    localparam int N_MAX = max2(max2(N_PWE, N_ACC), max2(N_WC, N_RC));
    localparam int CW    = $clog2(N_MAX + 1);

    logic              accept, capture;
    logic              phase_load, cycle_load, phase_done, cycle_done;
    logic [CW-1:0]     phase_val, cycle_val;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic [1:0]        lat_mask;

    sram_ctrl_fsm #(
        .N_PWE(N_PWE), .N_ACC(N_ACC), .N_WC(N_WC), .N_RC(N_RC), .CW(CW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_bmask  (req_bmask),
        .lat_mask   (lat_mask),
        .phase_done (phase_done),
        .cycle_done (cycle_done),
        .req_ready  (req_ready),
        .accept     (accept),
        .phase_load (phase_load),
        .phase_val  (phase_val),
        .cycle_load (cycle_load),
        .cycle_val  (cycle_val),
        .capture    (capture),
        .mem_cs_n   (mem_cs_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_lb_n   (mem_lb_n),
        .mem_ub_n   (mem_ub_n),
        .mem_dq_oe  (mem_dq_oe)
    );

    sram_cycle_timer #(.CW(CW)) u_phase_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (phase_val),
        .expired  (phase_done)
    );

    sram_cycle_timer #(.CW(CW)) u_cycle_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cycle_load),
        .load_val (cycle_val),
        .expired  (cycle_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_mask  <= '0;
        end else if (accept) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_mask  <= req_write ? req_bmask : 2'b11;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture)
                rsp_rdata <= mem_dq_in;
        end
    end

    assign mem_addr   = lat_addr;
    assign mem_dq_out = lat_wdata;

    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    a_r2_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

    a_r8_standby_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs_n && !$past(mem_cs_n)) |-> (mem_we_n && mem_oe_n));

endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;
    localparam int CLK_PERIOD = 15;
    localparam int EXP_NW = 3;  // max(ceil(40/15), ceil(25/15))
    localparam int EXP_NR = 4;  // max(ceil(55/15), ceil(25/15))
    localparam int EXP_NC = 4;  // ceil(55/15)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_bmask = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hBAD0;

    sram_async_ctrl #(.CLK_PERIOD_NS(CLK_PERIOD)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #(CLK_PERIOD/2.0) clk = ~clk;

    int unsigned n_checks = 0, n_fails = 0, cyc = 0;
    bit done = 0;

    typedef struct { logic [15:0] data; int unsigned acc_cyc; } exp_t;
    exp_t exp_q[$];
    logic [15:0] shadow  [int unsigned];
    logic [15:0] pin_mem [int unsigned];
    logic [1:0]  exp_lanes = 2'b11;
    int unsigned we_falls = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Memory pin model and pin monitor, both sampled on the falling edge
    bit prev_cs_n = 1'b1, prev_we_n = 1'b1;
    int unsigned last_start = 0, we_len = 0;
    bit have_start = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_cs_n && !mem_we_n) begin
                logic [15:0] w;
                w = pin_mem.exists(mem_addr) ? pin_mem[mem_addr] : 16'h0000;
                if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
                if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
                pin_mem[mem_addr] = w;
            end
            if (!mem_cs_n && !mem_oe_n && mem_we_n)
                mem_dq_in <= pin_mem.exists(mem_addr) ? pin_mem[mem_addr] : 16'h0000;
            else
                mem_dq_in <= 16'hBAD0;

            if (mem_dq_oe && !mem_oe_n) check("R6 bus contention", 1, 0);
            if (!mem_we_n) begin
                we_len++;
                check("R2 pins during pulse", {mem_cs_n, mem_oe_n, mem_dq_oe}, 3'b011);
                check("R3 lane enables", {~mem_ub_n, ~mem_lb_n}, exp_lanes);
            end
            if (!mem_oe_n)
                check("R5 read pins", {mem_cs_n, mem_we_n, mem_ub_n, mem_lb_n}, 4'b0100);
            if (prev_we_n && !mem_we_n) we_falls++;
            if (!prev_we_n && mem_we_n) begin
                check("R2 pulse width", we_len, EXP_NW);
                check("R2 hold cycle drives data", {mem_cs_n, mem_dq_oe}, 2'b01);
                we_len = 0;
            end
            if (prev_cs_n && !mem_cs_n) begin
                if (have_start)
                    check("R7 access spacing ok", (cyc - last_start) >= EXP_NC, 1);
                last_start = cyc;
                have_start = 1;
            end
            if (req_ready) check("R8 standby when idle", mem_cs_n, 1);
            prev_cs_n = mem_cs_n;
            prev_we_n = mem_we_n;
        end
    end

    // Scoreboard monitor for read responses
    bit prev_rv = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                if (prev_rv) check("R5 strobe lasts one cycle", 1, 0);
                if (exp_q.size() == 0) check("R5 unexpected response", 1, 0);
                else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R9 read data", rsp_rdata, e.data);
                    check("R5 read latency", cyc - e.acc_cyc, EXP_NR);
                end
            end
            prev_rv = rsp_valid;
        end
    end

    task automatic send(input bit wr, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] m);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_bmask = m;
        while (!req_ready) @(negedge clk);
        if (wr) exp_lanes = m;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        logic [15:0] w;
        w = shadow.exists(a) ? shadow[a] : 16'h0000;
        if (m[0]) w[7:0]  = d[7:0];
        if (m[1]) w[15:8] = d[15:8];
        shadow[a] = w;
        send(1, a, d, m);
    endtask

    task automatic do_read(input logic [17:0] a);
        exp_t e;
        e.data = shadow.exists(a) ? shadow[a] : 16'h0000;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        e.acc_cyc = cyc;
        exp_q.push_back(e);
        req_valid = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int unsigned f0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pins after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n},
              5'b11111);
        check("R1 driver off", mem_dq_oe, 0);
        check("R1 no response", rsp_valid, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 ready after reset", req_ready, 1);

        do_write(18'h00010, 16'h1234, 2'b11);
        do_read(18'h00010);
        // R3 lane-by-lane
        do_write(18'h00020, 16'hABCD, 2'b01);
        do_write(18'h00020, 16'h5E77, 2'b10);
        do_read(18'h00020);
        // R4 no-op write
        do_write(18'h00030, 16'hFFFF, 2'b11);
        repeat (6) @(negedge clk);
        f0 = we_falls;
        send(1, 18'h00030, 16'h0000, 2'b00);
        repeat (6) @(negedge clk);
        check("R4 no write pulse", we_falls, f0);
        do_read(18'h00030);
        // boundaries and back-to-back reads (R7)
        do_write(18'h3FFFF, 16'hC3A5, 2'b11);
        do_write(18'h00000, 16'h0F0F, 2'b10);
        do_read(18'h3FFFF);
        do_read(18'h00000);
        do_read(18'h00010);
        do_read(18'h00020);
        repeat (10) @(negedge clk);
        check("R9 all responses seen", exp_q.size(), 0);
        check("R8 idle select high", mem_cs_n, 1);
        check("R8 idle driver off", mem_dq_oe, 0);
        finish_run();
    end
endmodule